// File: doc/BRIEF.md
# Hashed Page Table Walker

This block turns a 32-bit effective address into a physical address by searching a hashed page table in memory. Callers use it when block translation has missed. Sixteen segment registers are held inside the block and loaded through a small write port. The top four bits of the effective address pick one of them. From the segment value and the page index the walker forms a hash. It then merges the hash with the table base value to address a group of eight 8-byte entries. It reads the first word of each entry in order until one matches the expected tag.

If the primary group has no matching entry, the walker searches again using the complemented hash and a tag with its hash-select bit set. On a hit it fetches the entry's second word and selects a protection key from the privilege mode. It then checks the two page-protection bits against the kind of access. If the access is allowed, it writes the second word back with the referenced bit set, and with the changed bit also set for data writes. Every walk ends with a one-cycle `done_o` pulse that carries either a physical address or a fault code with a status word.

Memory traffic uses one simple request/acknowledge port for 32-bit words, with at most one request outstanding.

Top module: `pt_walker`

## Requirements
- R1: `ea_i[31:28]` selects the segment register. A value written through `seg_we_i`/`seg_sel_i`/`seg_wdata_i` is used by every walk started after the write cycle. If bit 31 of the selected segment is set, the walk ends with fault code 1 and status 0, and no memory request is made.
- R2: On an instruction fetch (`fetch_i`=1) from a segment with bit 28 set, the walk ends with fault code 2 and status 0x10000000, and no memory request is made. Bit 28 has no effect on data accesses.
- R3: The group address is built from the table base and a 19-bit hash. Bits 31:25 come from base[31:25]. Bits 24:16 are base[24:16] OR (base[8:0] AND hash[18:10]). Bits 15:6 are hash[9:0], and bits 5:0 are zero. The primary hash is segment[18:0] XOR the zero-extended `ea_i[27:12]`.
- R4: The first word of entry i is read at group + 8*i, for i from 0 upward. The tag is 1 in bit 31, segment[23:0] in bits 30:7, the pass bit in bit 6, and `ea_i[27:22]` in bits 5:0. The first entry whose word equals the tag is used.
- R5: After eight non-matching entries in the primary pass, the walker repeats the scan with the complemented 19-bit hash and the pass bit set to 1.
- R6: A miss on both passes ends with fault code 3 and status 0x40000000. For a data write, 0x02000000 is added to the status. For a data access, `far_o` captures the effective address. Instruction fetches leave `far_o` unchanged.
- R7: The protection key is segment bit 30 when `user_i`=0 and segment bit 29 when `user_i`=1.
- R8: With PP as bits 1:0 of the second word, a protection fault occurs in three cases: key=1 with PP=00; key=1 with PP=01 on a write; PP=11 on a write. The fault ends the walk with fault code 4 and status 0x08000000, plus 0x02000000 for a data write, and `far_o` captures the effective address. No write-back is made. Instruction fetches count as reads.
- R9: A permitted walk writes the second word once, at entry + 4, with bit 8 set (referenced). Bit 7 (changed) is also set only for data writes. All other bits are unchanged.
- R10: A successful walk returns fault code 0, status 0 and `pa_o` = {second word[31:12], `ea_i[11:0]`}.
- R11: At most one memory request is outstanding. `mem_req_o` and `mem_addr_o` stay unchanged until `mem_ack_i` is seen.
- R12: `done_o` is a one-cycle pulse. `fault_o`, `status_o` and `pa_o` hold until the next walk ends. `start_i` is ignored while a walk is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| seg_we_i | input | 1 | Segment register write enable |
| seg_sel_i | input | 4 | Segment register index to write |
| seg_wdata_i | input | 32 | Segment register write value |
| tbase_i | input | 32 | Page table base value |
| start_i | input | 1 | Begin a walk (sampled when idle) |
| ea_i | input | 32 | Effective address |
| fetch_i | input | 1 | Access is an instruction fetch |
| write_i | input | 1 | Access is a data write |
| user_i | input | 1 | Access is made in user mode |
| mem_req_o | output | 1 | Memory request valid |
| mem_we_o | output | 1 | Memory request is a write |
| mem_addr_o | output | 32 | Memory word address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_ack_i | input | 1 | Memory request completed |
| mem_rdata_i | input | 32 | Memory read data, valid with ack |
| done_o | output | 1 | Walk finished (pulse) |
| fault_o | output | 3 | 0 none, 1 direct-store, 2 no-execute, 3 miss, 4 protection |
| status_o | output | 32 | Fault status word |
| pa_o | output | 32 | Translated physical address |
| far_o | output | 32 | Effective address of the last data fault |

## Verification
The hardest case to reach is a hit in the secondary group. It requires eight tag reads in the primary group that all fail, some of them by only one bit. The stimulus therefore fills the primary group with near-miss words: the correct tag with the pass bit set, or with one tag bit flipped. It then places the true tag in the last slot of the secondary group. Another hard case is the table-base merge, which only shows when both base[8:0] and the upper hash bits are nonzero. A run with a wide mask and a page index that drives hash[18:10] high covers it. The bench compares every request address against a behavioural model at each handshake.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  typedef enum logic [2:0] {
    FLT_NONE = 3'd0,
    FLT_DSEG = 3'd1,
    FLT_NOEX = 3'd2,
    FLT_MISS = 3'd3,
    FLT_PROT = 3'd4
  } flt_e;

  typedef enum logic [1:0] {
    S_IDLE,
    S_TAG,
    S_DATA,
    S_WB
  } st_e;

  localparam logic [31:0] STS_NOEX = 32'h1000_0000;
  localparam logic [31:0] STS_MISS = 32'h4000_0000;
  localparam logic [31:0] STS_PROT = 32'h0800_0000;
  localparam logic [31:0] STS_WR   = 32'h0200_0000;
  localparam logic [31:0] REF_BIT  = 32'h0000_0100;
  localparam logic [31:0] CHG_BIT  = 32'h0000_0080;
endpackage

// File: rtl/ptw_segs.sv
module ptw_segs #(
  parameter int NUM_SEG = 16,
  parameter int DW      = 32,
  localparam int SEL_W  = $clog2(NUM_SEG)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [SEL_W-1:0] wsel_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [SEL_W-1:0] rsel_i,
  output logic [DW-1:0]    rdata_o
);
  logic [DW-1:0] regs_q [NUM_SEG];

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  regs_q[g] <= '0;
      else if (we_i && wsel_i == SEL_W'(g))         regs_q[g] <= wdata_i;
    end
  end

  assign rdata_o = regs_q[rsel_i];
endmodule

// File: rtl/ptw_hash.sv
module ptw_hash #(
  parameter int ENTRIES     = 8,
  parameter int ENTRY_BYTES = 8,
  localparam int IDX_W      = $clog2(ENTRIES),
  localparam int OFS_W      = $clog2(ENTRY_BYTES)
) (
  input  logic [31:0]      seg_i,
  input  logic [31:0]      ea_i,
  input  logic [31:0]      base_i,
  input  logic             pass_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [31:0]      tag_addr_o,
  output logic [31:0]      match_o
);
  logic [15:0] pidx;
  logic [18:0] h_pri, h_sel;
  logic [31:0] grp;

  always_comb begin
    pidx  = ea_i[27:12];
    h_pri = seg_i[18:0] ^ {3'b000, pidx};
    h_sel = pass_i ? ~h_pri : h_pri;
    // masked merge of upper hash into base
    grp   = {base_i[31:25], base_i[24:16] | (base_i[8:0] & h_sel[18:10]),
             h_sel[9:0], 6'b0};
    tag_addr_o = grp + (32'(idx_i) << OFS_W);
    match_o    = {1'b1, seg_i[23:0], pass_i, pidx[15:10]};
  end
endmodule

// File: rtl/ptw_prot.sv
module ptw_prot (
  input  logic [31:0] seg_i,
  input  logic        user_i,
  input  logic        wr_i,
  input  logic [1:0]  pp_i,
  output logic        viol_o
);
  logic key;
  always_comb begin
    key    = user_i ? seg_i[29] : seg_i[30];
    viol_o = (key && (pp_i == 2'b00 || (pp_i == 2'b01 && wr_i))) ||
             (pp_i == 2'b11 && wr_i);
  end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import ptw_pkg::*;
#(
  parameter int NUM_SEG     = 16,
  parameter int ENTRIES     = 8,
  parameter int ENTRY_BYTES = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       seg_we_i,
  input  logic [$clog2(NUM_SEG)-1:0] seg_sel_i,
  input  logic [31:0]                seg_wdata_i,
  input  logic [31:0]                tbase_i,
  input  logic                       start_i,
  input  logic [31:0]                ea_i,
  input  logic                       fetch_i,
  input  logic                       write_i,
  input  logic                       user_i,
  output logic                       mem_req_o,
  output logic                       mem_we_o,
  output logic [31:0]                mem_addr_o,
  output logic [31:0]                mem_wdata_o,
  input  logic                       mem_ack_i,
  input  logic [31:0]                mem_rdata_i,
  output logic                       done_o,
  output logic [2:0]                 fault_o,
  output logic [31:0]                status_o,
  output logic [31:0]                pa_o,
  output logic [31:0]                far_o
);
  localparam int SEL_W = $clog2(NUM_SEG);
  localparam int IDX_W = $clog2(ENTRIES);

  st_e              st_q;
  logic [31:0]      ea_q, ent_q, w1_q;
  logic             fetch_q, wr_q, user_q, pass_q;
  logic [IDX_W-1:0] idx_q;
  logic             req_q, we_q, done_q;
  logic [31:0]      addr_q, wdata_q, status_q, pa_q, far_q;
  flt_e             fault_q;

  logic [SEL_W-1:0] rsel;
  logic [31:0]      seg;
  logic [31:0]      tag_addr, match;
  logic             viol;

  assign rsel = (st_q == S_IDLE) ? ea_i[31 -: SEL_W] : ea_q[31 -: SEL_W];

  ptw_segs #(.NUM_SEG(NUM_SEG), .DW(32)) u_segs (
    .clk_i, .rst_ni,
    .we_i   (seg_we_i),
    .wsel_i (seg_sel_i),
    .wdata_i(seg_wdata_i),
    .rsel_i (rsel),
    .rdata_o(seg)
  );

  ptw_hash #(.ENTRIES(ENTRIES), .ENTRY_BYTES(ENTRY_BYTES)) u_hash (
    .seg_i     (seg),
    .ea_i      (ea_q),
    .base_i    (tbase_i),
    .pass_i    (pass_q),
    .idx_i     (idx_q),
    .tag_addr_o(tag_addr),
    .match_o   (match)
  );

  ptw_prot u_prot (
    .seg_i (seg),
    .user_i(user_q),
    .wr_i  (wr_q),
    .pp_i  (mem_rdata_i[1:0]),
    .viol_o(viol)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= S_IDLE;  ea_q <= '0;  ent_q <= '0;  w1_q <= '0;
      fetch_q <= 1'b0; wr_q <= 1'b0; user_q <= 1'b0; pass_q <= 1'b0;
      idx_q <= '0;     req_q <= 1'b0; we_q <= 1'b0; done_q <= 1'b0;
      addr_q <= '0;    wdata_q <= '0; status_q <= '0; pa_q <= '0;
      far_q <= '0;     fault_q <= FLT_NONE;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        S_IDLE: if (start_i) begin
          ea_q    <= ea_i;
          fetch_q <= fetch_i;
          wr_q    <= write_i && !fetch_i;
          user_q  <= user_i;
          pass_q  <= 1'b0;
          idx_q   <= '0;
          if (seg[31]) begin
            done_q <= 1'b1; fault_q <= FLT_DSEG; status_q <= '0;
          end else if (fetch_i && seg[28]) begin
            done_q <= 1'b1; fault_q <= FLT_NOEX; status_q <= STS_NOEX;
          end else begin
            st_q <= S_TAG;
          end
        end
        S_TAG: begin
          if (!req_q) begin
            req_q <= 1'b1; we_q <= 1'b0; addr_q <= tag_addr;
          end else if (mem_ack_i) begin
            req_q <= 1'b0;
            if (mem_rdata_i == match) begin
              ent_q <= addr_q;
              st_q  <= S_DATA;
            end else if (idx_q == IDX_W'(ENTRIES - 1)) begin
              idx_q <= '0;
              if (!pass_q) pass_q <= 1'b1;
              else begin
                st_q     <= S_IDLE;
                done_q   <= 1'b1;
                fault_q  <= FLT_MISS;
                status_q <= STS_MISS | (wr_q ? STS_WR : '0);
                if (!fetch_q) far_q <= ea_q;
              end
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end
        end
        S_DATA: begin
          if (!req_q) begin
            req_q <= 1'b1; we_q <= 1'b0; addr_q <= ent_q + 32'd4;
          end else if (mem_ack_i) begin
            req_q <= 1'b0;
            w1_q  <= mem_rdata_i;
            if (viol) begin
              st_q     <= S_IDLE;
              done_q   <= 1'b1;
              fault_q  <= FLT_PROT;
              status_q <= STS_PROT | (wr_q ? STS_WR : '0);
              if (!fetch_q) far_q <= ea_q;
            end else begin
              st_q <= S_WB;
            end
          end
        end
        S_WB: begin
          if (!req_q) begin
            req_q   <= 1'b1;
            we_q    <= 1'b1;
            addr_q  <= ent_q + 32'd4;
            wdata_q <= w1_q | REF_BIT | (wr_q ? CHG_BIT : '0);
          end else if (mem_ack_i) begin
            req_q    <= 1'b0;
            we_q     <= 1'b0;
            st_q     <= S_IDLE;
            done_q   <= 1'b1;
            fault_q  <= FLT_NONE;
            status_q <= '0;
            pa_q     <= {w1_q[31:12], ea_q[11:0]};
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign mem_req_o   = req_q;
  assign mem_we_o    = we_q;
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = wdata_q;
  assign done_o      = done_q;
  assign fault_o     = fault_q;
  assign status_o    = status_q;
  assign pa_o        = pa_q;
  assign far_o       = far_q;

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_q && !mem_ack_i |=> req_q && $stable(addr_q) && $stable(we_q)); // R11
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q); // R12
  AST_DONE_NO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> !req_q); // R11
  AST_WB_SECOND_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_q && we_q |-> addr_q[2:0] == 3'b100 && st_q == S_WB); // R9
  AST_PROT_NO_WB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q && fault_q == FLT_PROT |-> !$past(we_q)); // R8
  AST_FAST_FAULT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q && (fault_q == FLT_DSEG || fault_q == FLT_NOEX) |-> $past(st_q) == S_IDLE); // R1
endmodule

// File: tb/pt_walker_tb_top.sv
module pt_walker_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        seg_we = 1'b0;
  logic [3:0]  seg_sel = '0;
  logic [31:0] seg_wdata = '0, tbase = 32'h0010_0000;
  logic        start = 1'b0, fetch = 1'b0, wr = 1'b0, user = 1'b0;
  logic [31:0] ea = '0;
  logic        mem_req, mem_we, mem_ack = 1'b0, done;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
  logic [2:0]  fault;
  logic [31:0] status, pa, far;

  pt_walker dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .seg_we_i(seg_we), .seg_sel_i(seg_sel), .seg_wdata_i(seg_wdata),
    .tbase_i(tbase), .start_i(start), .ea_i(ea), .fetch_i(fetch),
    .write_i(wr), .user_i(user),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata),
    .done_o(done), .fault_o(fault), .status_o(status), .pa_o(pa), .far_o(far)
  );

  int total = 0, bad = 0;
  string cur = "R0";

  typedef struct { bit we; logic [31:0] a; logic [31:0] d; } acc_t;
  acc_t expq[$];
  logic [31:0] mem [int unsigned];
  logic [31:0] segm [16];
  logic [2:0]  e_fault;
  logic [31:0] e_status, e_pa, e_far = '0;

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  function automatic logic [31:0] grp_of(input logic [31:0] sv, input logic [31:0] e,
                                         input bit p, input logic [31:0] b);
    logic [31:0] h;
    h = (sv & 32'h7FFFF) ^ ((e >> 12) & 32'hFFFF);
    if (p) h = ~h & 32'h7FFFF;
    return (b & 32'hFE00_0000) | (b & 32'h01FF_0000) |
           (((b & 32'h1FF) << 16) & ((h & 32'h7FC00) << 6)) | ((h & 32'h3FF) << 6);
  endfunction

  function automatic logic [31:0] tag_of(input logic [31:0] sv, input logic [31:0] e, input bit p);
    return 32'h8000_0000 | ((sv & 32'hFF_FFFF) << 7) | (32'(p) << 6) | (((e >> 12) & 32'hFFFF) >> 10);
  endfunction

  task automatic chk(input string r, input string what, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s got=%h exp=%h", r, what, got, exp);
    end
  endtask

  // behavioural model of one walk: fills expq and expected results
  task automatic model(input logic [31:0] e, input bit f, input bit w, input bit u);
    logic [31:0] sv, a, w1;
    bit hit, key, dw;
    int pp;
    acc_t x;
    sv = segm[e[31:28]];
    dw = w && !f;
    expq.delete();
    hit = 0; a = 0;
    if (sv[31]) begin e_fault = 1; e_status = 0; return; end
    if (f && sv[28]) begin e_fault = 2; e_status = 32'h1000_0000; return; end
    for (int p = 0; p < 2 && !hit; p++)
      for (int i = 0; i < 8 && !hit; i++) begin
        a = grp_of(sv, e, p[0], tbase) + 32'(8 * i);
        x.we = 0; x.a = a; x.d = 0; expq.push_back(x);
        if (rd(a) == tag_of(sv, e, p[0])) hit = 1;
      end
    if (!hit) begin
      e_fault = 3; e_status = 32'h4000_0000 | (dw ? 32'h0200_0000 : 0);
      if (!f) e_far = e;
      return;
    end
    x.we = 0; x.a = a + 4; x.d = 0; expq.push_back(x);
    w1 = rd(a + 4);
    key = u ? sv[29] : sv[30];
    pp = int'(w1[1:0]);
    if ((key && (pp == 0 || (pp == 1 && dw))) || (pp == 3 && dw)) begin
      e_fault = 4; e_status = 32'h0800_0000 | (dw ? 32'h0200_0000 : 0);
      if (!f) e_far = e;
      return;
    end
    x.we = 1; x.a = a + 4; x.d = w1 | 32'h100 | (dw ? 32'h80 : 0); expq.push_back(x);
    e_fault = 0; e_status = 0; e_pa = {w1[31:12], e[11:0]};
  endtask

  // memory responder, checks each access against the model queue
  always @(negedge clk) begin
    if (mem_req && !mem_ack) begin
      acc_t x;
      if (expq.size() == 0) begin
        total++; bad++;
        $display("FAIL %s unexpected access got=%h exp=none", cur, mem_addr);
      end else begin
        x = expq.pop_front();
        chk(cur, "access addr", mem_addr, x.a);
        chk(cur, "access we", 32'(mem_we), 32'(x.we));
        if (x.we) chk("R9", "write-back data", mem_wdata, x.d);
      end
      if (mem_we) mem[mem_addr] = mem_wdata;
      mem_rdata <= rd(mem_addr);
      mem_ack   <= 1'b1;
    end else begin
      mem_ack <= 1'b0;
    end
  end

  task automatic set_seg(input int i, input logic [31:0] v);
    @(negedge clk);
    seg_we = 1; seg_sel = 4'(i); seg_wdata = v; segm[i] = v;
    @(negedge clk);
    seg_we = 0;
  endtask

  task automatic run(input string r, input logic [31:0] e, input bit f, input bit w,
                     input bit u, input bit poke);
    int n;
    cur = r;
    model(e, f, w, u);
    @(negedge clk);
    start = 1; ea = e; fetch = f; wr = w; user = u;
    @(negedge clk);
    start = 0;
    n = 0;
    while (!done && n < 400) begin
      if (poke && n == 3) begin start = 1; ea = 32'hF0F0_1234; fetch = 0; wr = 1; end
      else if (poke && n == 4) start = 0;
      @(negedge clk);
      n++;
    end
    if (!done) begin total++; bad++; $display("FAIL %s timeout got=busy exp=done", r); end
    chk(r, "fault", 32'(fault), 32'(e_fault));
    chk(r, "status", status, e_status);
    if (e_fault == 0) chk(r, "pa", pa, e_pa);
    chk(r, "far", far, e_far);
    chk(r, "accesses left", 32'(expq.size()), 0);
    @(negedge clk);
    chk("R12", "done pulse", 32'(done), 0);
    chk("R12", "fault held", 32'(fault), 32'(e_fault));
  endtask

  task automatic put(input logic [31:0] e, input bit p, input int i,
                     input logic [31:0] w0, input logic [31:0] w1);
    logic [31:0] g;
    g = grp_of(segm[e[31:28]], e, p, tbase) + 32'(8 * i);
    mem[g] = w0; mem[g + 4] = w1;
  endtask

  function automatic logic [31:0] tg(input logic [31:0] e, input bit p);
    return tag_of(segm[e[31:28]], e, p);
  endfunction

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      total++; bad++;
      $display("FAIL watchdog got=hung exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) segm[i] = '0;
    repeat (3) @(negedge clk);
    chk("R12", "reset done", 32'(done), 0);
    chk("R11", "reset req", 32'(mem_req), 0);
    chk("R10", "reset fault", 32'(fault), 0);
    rst_n = 1;
    set_seg(0, 32'h0000_0123);
    set_seg(1, 32'h6000_0456);
    set_seg(2, 32'h4000_0789);
    set_seg(3, 32'h8000_0000);
    set_seg(4, 32'h1000_0ABC);
    set_seg(5, 32'h2000_0DEF);

    // R4 R10 R9: primary hit in slot 0, data read
    mem.delete();
    put(32'h0000_5ABC, 0, 0, tg(32'h0000_5ABC, 0), 32'h0ABC_D002);
    run("R10", 32'h0000_5ABC, 0, 0, 0, 0);
    chk("R9", "ref bit stored", rd(grp_of(segm[0], 32'h0000_5ABC, 0, tbase) + 4), 32'h0ABC_D102);

    // R4 first match wins, near-miss words before it; data write sets changed
    mem.delete();
    put(32'h0001_2345, 0, 0, tg(32'h0001_2345, 1), 32'h7777_7002);
    put(32'h0001_2345, 0, 1, tg(32'h0001_2345, 0) ^ 32'h1, 32'h7777_7002);
    put(32'h0001_2345, 0, 3, tg(32'h0001_2345, 0), 32'h1111_1001);
    put(32'h0001_2345, 0, 5, tg(32'h0001_2345, 0), 32'h2222_2002);
    run("R4", 32'h0001_2345, 0, 1, 0, 0);

    // R5: secondary hit in last slot, fetch, primary full of near misses
    mem.delete();
    for (int i = 0; i < 8; i++) put(32'h0003_3000, 0, i, tg(32'h0003_3000, 1), 32'h0);
    put(32'h0003_3000, 1, 7, tg(32'h0003_3000, 1), 32'h0BAD_0002);
    run("R5", 32'h0003_3000, 1, 0, 0, 0);

    // R6: misses
    mem.delete();
    run("R6", 32'h0007_7777, 0, 0, 0, 0);
    run("R6", 32'h0008_8888, 0, 1, 0, 0);
    run("R6", 32'h0009_9999, 1, 1, 0, 0);

    // R1: direct-store segment; R2: no-execute
    run("R1", 32'h3000_1000, 0, 0, 0, 0);
    run("R2", 32'h4000_2000, 1, 0, 0, 0);
    mem.delete();
    put(32'h4000_2000, 0, 2, tg(32'h4000_2000, 0), 32'h0456_7002);
    run("R2", 32'h4000_2000, 0, 0, 0, 0);

    // R7 R8: keys and protection
    mem.delete();
    put(32'h1000_1000, 0, 0, tg(32'h1000_1000, 0), 32'h0000_1000);
    run("R8", 32'h1000_1000, 0, 0, 0, 0);
    mem.delete();
    put(32'h2000_1000, 0, 0, tg(32'h2000_1000, 0), 32'h0000_2000);
    run("R7", 32'h2000_1000, 0, 0, 1, 0);
    mem.delete();
    put(32'h5000_1000, 0, 1, tg(32'h5000_1000, 0), 32'h0000_3001);
    run("R8", 32'h5000_1000, 0, 1, 1, 0);
    mem.delete();
    put(32'h5000_1000, 0, 1, tg(32'h5000_1000, 0), 32'h0000_3001);
    run("R7", 32'h5000_1000, 0, 1, 0, 0);
    mem.delete();
    put(32'h0000_4000, 0, 4, tg(32'h0000_4000, 0), 32'h0000_4003);
    run("R8", 32'h0000_4000, 0, 1, 0, 0);
    mem.delete();
    put(32'h0000_4000, 0, 4, tg(32'h0000_4000, 0), 32'h0000_4003);
    run("R8", 32'h0000_4000, 0, 0, 0, 0);
    mem.delete();
    put(32'h1000_6000, 0, 6, tg(32'h1000_6000, 0), 32'h0000_6002);
    run("R7", 32'h1000_6000, 0, 1, 0, 0);
    mem.delete();
    put(32'h1000_7000, 0, 0, tg(32'h1000_7000, 0), 32'h0000_7000);
    run("R8", 32'h1000_7000, 1, 0, 0, 0);

    // R3: masked base merge with high hash bits
    tbase = 32'h1240_01FF;
    mem.delete();
    put(32'h00FF_F123, 0, 2, tg(32'h00FF_F123, 0), 32'h0CCC_C002);
    run("R3", 32'h00FF_F123, 0, 0, 0, 0);
    mem.delete();
    put(32'h00FF_F123, 1, 0, tg(32'h00FF_F123, 1), 32'h0DDD_D002);
    run("R3", 32'h00FF_F123, 0, 1, 0, 0);
    tbase = 32'h0010_0000;

    // R12: start while busy is ignored
    mem.delete();
    put(32'h0002_2000, 0, 6, tg(32'h0002_2000, 0), 32'h0EEE_E002);
    run("R12", 32'h0002_2000, 0, 0, 0, 1);

    // R1: segment rewrite takes effect
    set_seg(0, 32'h0000_0999);
    mem.delete();
    put(32'h0000_5ABC, 0, 0, tg(32'h0000_5ABC, 0), 32'h0FED_C002);
    run("R1", 32'h0000_5ABC, 0, 0, 0, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule